// File: doc/BRIEF.md
# Five-Bit Bidirectional GPIO Port

This block is a five-bit general-purpose I/O port on a small register bus. Each bit has an output data latch and a direction latch. A direction bit of 1 makes the bit an input, with its driver released. A direction bit of 0 makes it an output that drives the latch value. The pad itself sits outside the block. The port brings out separate output-value, output-enable and input vectors, so the surrounding logic or a testbench can model pull-ups and external drivers.

Reads of the data register return the synchronised pin levels, not the latch contents. Single-bit set and clear strobes therefore work as read-modify-write operations: they take the current pin levels, change one bit, and write all five bits back into the latch. Bit 4 is open-drain. It can only pull its pin low, and its synchronised level is also sent out as a clock input for a timer.

Top module: `gpio5_port`

## Requirements
- R1: After reset all direction bits are 1, all output enables are low and the data latch is 0. A direction read (`reg_sel`=1) returns 0x1F.
- R2: A write with `reg_sel`=1 loads `wdata[4:0]` into the direction latch. Bit value 1 makes the pin an input (`pin_oe` low) and 0 makes it an output.
- R3: Bits 0 to 3 configured as outputs drive `pin_oe`=1 and present their data latch bit on `pin_out`.
- R4: A write with `reg_sel`=0 loads `wdata[4:0]` into the data latch only. On a pin configured as an input, the new value does not reach the pin until its direction bit is cleared.
- R5: A read with `reg_sel`=0 returns in bits 4:0 the pin levels from `pin_in` after a two-flop synchroniser. A stable pin change is visible on `rdata` after the second rising clock edge.
- R6: `rdata[7:5]` always reads 0, whichever register is selected, including after writing 0xFF to the direction register.
- R7: `bit_set` (or `bit_clr`) loads the data latch with the synchronised pin levels, with bit `bit_idx` forced to 1 (or 0). Latch bits of input pins therefore take on the pin levels.
- R8: A bit strobe with `bit_idx` of 5, 6 or 7 forces no bit. The latch is still reloaded with the synchronised pin levels.
- R9: In a cycle with `wr_en` high, both bit strobes are ignored. When `bit_set` and `bit_clr` are both high, set wins.
- R10: Bit 4 is open-drain. `pin_out[4]` is always 0, and `pin_oe[4]` is high only when direction bit 4 is 0 and data latch bit 4 is 0. A latch value of 1 releases the pin.
- R11: `tmr_clk` equals the synchronised level of pin 4, which is the same value as `rdata[4]` on a data read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register select: 0 data, 1 direction |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| bit_set | input | 1 | Read-modify-write set of one bit |
| bit_clr | input | 1 | Read-modify-write clear of one bit |
| bit_idx | input | 3 | Bit index for set/clear |
| pin_in | input | 5 | Pad levels seen by the port |
| pin_out | output | 5 | Value to drive on each pad |
| pin_oe | output | 5 | Drive enable for each pad |
| tmr_clk | output | 1 | Synchronised pin 4 level for a timer |

## Verification
Random cycles mix direction masks, latch values, external pin levels and every kind of operation. They are checked against a bench model of the pad, so that a read of driven pins and a read of floating pins give different answers. Directed cases set up an input pin whose level differs from its latch and then apply a bit set to a different bit. Only a true read-modify-write copies that level into the latch, which the bench exposes by switching the pin to output. Further directed cases cover the open-drain bit with latch values 0 and 1 and with the external level both high and low, out-of-range bit indices, and simultaneous strobes. These separate the release of bit 4 from a push-pull drive and show which operation takes priority.

// File: rtl/gpio5_port.sv
module gpio5_port #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_sel,
  input  logic         wr_en,
  input  logic [7:0]   wdata,
  output logic [7:0]   rdata,
  input  logic         bit_set,
  input  logic         bit_clr,
  input  logic [2:0]   bit_idx,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic         tmr_clk
);
  localparam int OD = W - 1;

  logic [W-1:0] data_q, dir_q, meta_q, sync_q, mask;
  logic [1:0]   age_q;

  assign mask = {{(W-1){1'b0}}, 1'b1} << bit_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '1;
      meta_q <= '0;
      sync_q <= '0;
      age_q  <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
      if (wr_en) begin
        if (reg_sel) dir_q  <= wdata[W-1:0];
        else         data_q <= wdata[W-1:0];
      end else if (bit_set) begin
        data_q <= sync_q | mask;
      end else if (bit_clr) begin
        data_q <= sync_q & ~mask;
      end
    end
  end

  assign rdata   = {{(8-W){1'b0}}, reg_sel ? dir_q : sync_q};
  assign tmr_clk = sync_q[OD];

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_pad
      if (g == OD) begin : g_od
        assign pin_out[g] = 1'b0;
        assign pin_oe[g]  = ~dir_q[g] & ~data_q[g];
      end else begin : g_pp
        assign pin_out[g] = data_q[g];
        assign pin_oe[g]  = ~dir_q[g];
      end
    end
  endgenerate

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel) |=> (dir_q == $past(wdata[W-1:0]))); // R2
  AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_sel) |=> (data_q == $past(wdata[W-1:0]))); // R4
  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (sync_q == $past(pin_in, 2))); // R5
  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[7:W] == '0); // R6
  AST_RMW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && bit_set) |=> (data_q == ($past(sync_q) | ($past(mask))))); // R7
  AST_OD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe[OD] |-> (!pin_out[OD] && !dir_q[OD] && !data_q[OD])); // R10
  AST_TMR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (rdata[OD] == tmr_clk)); // R11
endmodule

// File: tb/gpio5_port_bench.sv
module gpio5_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0, wr_en = 1'b0, bit_set = 1'b0, bit_clr = 1'b0;
  logic [7:0] wdata = '0;
  logic [2:0] bit_idx = '0;
  logic [7:0] rdata;
  logic [4:0] pin_in, pin_out, pin_oe, ext = 5'h1F;
  logic       tmr_clk;
  logic [4:0] m_data, m_dir;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  gpio5_port u_gpio5_port (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .bit_set(bit_set), .bit_clr(bit_clr), .bit_idx(bit_idx),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .tmr_clk(tmr_clk));

  for (genvar i = 0; i < 5; i++) begin : g_pad
    assign pin_in[i] = pin_oe[i] ? pin_out[i] : ext[i];
  end

  function automatic logic [4:0] exp_oe(logic [4:0] d, logic [4:0] r);
    return {~r[4] & ~d[4], ~r[3:0]};
  endfunction

  function automatic logic [4:0] exp_pad(logic [4:0] d, logic [4:0] r, logic [4:0] e);
    logic [4:0] oe = exp_oe(d, r);
    logic [4:0] p;
    for (int i = 0; i < 4; i++) p[i] = oe[i] ? d[i] : e[i];
    p[4] = oe[4] ? 1'b0 : e[4];
    return p;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(string req);
    logic [4:0] p = exp_pad(m_data, m_dir, ext);
    reg_sel = 1'b0; #1;
    chk({req, " R5 port read"}, rdata, {3'b0, p});
    chk({req, " R11 timer clock"}, {7'b0, tmr_clk}, {7'b0, p[4]});
    reg_sel = 1'b1; #1;
    chk({req, " R6 dir read"}, rdata, {3'b0, m_dir});
    chk({req, " R3 R10 oe"}, {3'b0, pin_oe}, {3'b0, exp_oe(m_data, m_dir)});
    chk({req, " R3 R10 out"}, {3'b0, pin_out}, {4'b0, m_data[3:0] & ~m_dir[3:0]} & 8'h0F
        | {3'b0, 1'b0, pin_out[3:0] & m_dir[3:0]});
  endtask

  task automatic op(bit we, bit sel, logic [7:0] wd, bit bs, bit bc, logic [2:0] idx);
    logic [4:0] p = exp_pad(m_data, m_dir, ext);
    logic [4:0] mk = (idx < 5) ? (5'd1 << idx) : 5'd0;
    @(negedge clk);
    wr_en = we; reg_sel = sel; wdata = wd; bit_set = bs; bit_clr = bc; bit_idx = idx;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; bit_set = 1'b0; bit_clr = 1'b0;
    if (we) begin
      if (sel) m_dir = wd[4:0];
      else     m_data = wd[4:0];
    end else if (bs) m_data = p | mk;
    else if (bc) m_data = p & ~mk;
  endtask

  initial begin
    void'($urandom(32'd4242));
    m_data = '0; m_dir = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    reg_sel = 1'b1; #1;
    chk("R1 dir after reset", rdata, 8'h1F);
    chk("R1 oe after reset", {3'b0, pin_oe}, 8'h00);
    settle();
    check_all("R1");

    // R6 unused bits and R2 direction load
    op(1, 1, 8'hFF, 0, 0, 0); settle(); check_all("R6 R2");
    // R4 write to input pins does not reach them
    ext = 5'h0A;
    op(1, 0, 8'hF5, 0, 0, 0); settle(); check_all("R4");
    op(1, 1, 8'h10, 0, 0, 0); settle(); check_all("R3 R2");

    // R7 read-modify-write corrupts latch bit of an input pin
    op(1, 1, 8'h1F, 0, 0, 0);
    op(1, 0, 8'h01, 0, 0, 0);
    ext = 5'h1E; settle();
    op(0, 0, 8'h00, 1, 0, 3'd1); settle();
    op(1, 1, 8'h00, 0, 0, 0); settle();
    chk("R7 latch bit0 taken from pin", {7'b0, pin_out[0]}, 8'h00);
    chk("R7 bit1 set", {7'b0, pin_out[1]}, 8'h01);
    check_all("R7");

    // R10 open drain: latch 1 releases, latch 0 pulls low
    ext = 5'h10;
    op(1, 0, 8'h10, 0, 0, 0); settle(); check_all("R10 release high");
    ext = 5'h00; settle(); check_all("R10 release low");
    ext = 5'h10;
    op(0, 0, 8'h00, 0, 1, 3'd4); settle();
    chk("R10 pull low oe", {7'b0, pin_oe[4]}, 8'h01);
    chk("R11 timer low", {7'b0, tmr_clk}, 8'h00);
    check_all("R10 R11");

    // R8 out of range index
    op(1, 1, 8'h1F, 0, 0, 0); ext = 5'h15; settle();
    op(0, 0, 8'h00, 1, 0, 3'd6); op(1, 1, 8'h00, 0, 0, 0); settle();
    chk("R8 latch is pin image", {3'b0, pin_out & 5'h0F}, 8'h05);
    check_all("R8");

    // R9 priority
    op(1, 0, 8'h00, 1, 1, 3'd2); settle();
    chk("R9 write beats strobe", {3'b0, pin_out}, 8'h00);
    op(0, 0, 8'h00, 1, 1, 3'd2); settle();
    chk("R9 set beats clear", {7'b0, pin_out[2]}, 8'h01);
    check_all("R9");

    for (int k = 0; k < 400; k++) begin
      int kind = $urandom % 6;
      logic [7:0] wd = 8'($urandom);
      logic [2:0] ix = 3'($urandom);
      ext = 5'($urandom);
      settle();
      check_all("rand");
      case (kind)
        0: op(1, 0, wd, 0, 0, ix);
        1: op(1, 1, wd, 0, 0, ix);
        2: op(0, 0, wd, 1, 0, ix);
        3: op(0, 0, wd, 0, 1, ix);
        4: op(0, 0, wd, 1, 1, ix);
        default: op(1, 0, wd, 1, 0, ix);
      endcase
    end
    settle();
    check_all("final");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule